// File: doc/BRIEF.md
# Segmented Address Extension Unit

This block sits next to a processor core and turns each 32-bit logical address into a 36-bit physical address. It looks the address up in a bank of programmable segments. Every segment is a pair of words. The high word gives a logical base and a size code. The low word gives a replacement address and six access-permission bits. Segments may overlap. When they do, the highest-numbered segment that matches does the translation. Two segments are loaded at reset, so the lower and upper halves of the logical space translate one-to-one before software writes anything.

Requests enter on a valid/ready stream and carry three things: an address, an access kind (read, write or execute) and a privilege mode. The lookup itself is combinational. The result is held in a one-entry output register and comes out on a valid/ready response stream one cycle after the request is accepted.

Back-pressure works as follows. While a response is pending and `rsp_ready` is low, `req_ready` drops and the response fields stay frozen. Once `rsp_ready` rises, a new request can be accepted on the same edge that retires the old response.

Software programs the segments through a plain register port. The port has a single-cycle write strobe and a combinational read.

Top module: `seg_xlate_unit`

## Requirements
- R1: Reset loads the segments as follows:
  - Segment 0 reads high `0x0000001E` and low `0x0000003F`.
  - Segment 1 reads high `0x8000001E` and low `0x0800003F`.
  - Every other segment reads zero.
  - No response is pending, and `req_ready` is 1.
- R2: Register addressing is `cfg_addr = {segment index, word select}`, where word select 1 is the high word and 0 is the low word.
  - The high word keeps bits [31:12] as the base and bits [4:0] as the size code; bits [11:5] read as zero.
  - The low word keeps bits [31:8] as the replacement and bits [5:0] as the permissions; bits [7:6] read as zero whatever was written.
- R3: Size codes 0x0B to 0x1F are enabled segments.
  - A code c gives a segment of 2^(c+1) bytes.
  - Matching compares only the logical address bits at or above bit c+1, so base bits below the segment size are ignored.
  - A code below 0x0B disables the segment.
- R4: On a hit, the 36-bit physical address is built from two parts. Bits [35:12] come from the replacement field, low word bits [31:8]. Every bit below the segment size is taken from the logical address instead.
- R5: When several enabled segments match, the highest-numbered one supplies the translation, and `rsp_seg` reports its index.
- R6: Permission bits in the low word are: [0] user read, [1] user write, [2] user execute, [3] supervisor read, [4] supervisor write, [5] supervisor execute.
  - `req_kind` encodes 0 = read, 1 = write, 2 = execute.
  - `req_priv` encodes 1 = supervisor, 0 = user.
  - If the selected bit is clear, the response is fault 2 with physical address 0, and `rsp_seg` still reports the matching segment.
- R7: An address that matches no enabled segment gives fault 1, physical address 0 and `rsp_seg` 0. A successful translation gives fault 0.
- R8: `req_kind` 3 is reserved. A matched request of kind 3 always gives fault 2.
- R9: A request accepted on a clock edge has its response valid right after that edge.
- R10: While `rsp_valid` is high and `rsp_ready` is low:
  - the response fields stay unchanged;
  - `req_ready` is low;
  - a new request waits until `rsp_ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 5 | {segment index, high-word select} |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | 32 | Logical address |
| req_kind | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| req_priv | input | 1 | 1 supervisor, 0 user |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed when high with rsp_valid |
| rsp_paddr | output | 36 | Physical address, zero on fault |
| rsp_fault | output | 2 | 0 ok, 1 miss, 2 permission |
| rsp_seg | output | 4 | Index of the segment used |

## Verification
The bench targets six corner cases, each with a visible failure mode:

- **Overlap priority.** A 1 MB segment is laid over the reset-time upper half. A design that picks the lowest match would return the identity address instead of the remapped one.
- **Segment edges.** The smallest 4 KB segment is tested at its last byte and at the first byte past it. A design with an off-by-one in the size code would swallow or drop addresses there.
- **Base alignment.** A base with set bits below the segment size must still match. A design that compared the full base would miss.
- **Disabled codes.** A size code just below the enable threshold must be ignored, so a design that treated it as enabled would wrongly claim addresses.
- **Permissions.** All six permission selections are driven, plus the reserved kind, to catch a swapped bit order. The bench also tries a replacement address above 4 GB, which catches a truncated 32-bit path.
- **Stall.** A stalled response must hold steady and block new requests. A design without a proper stall would overwrite the response or drop the waiting request.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  localparam int LA_W     = 32;
  localparam int PA_W     = 36;
  localparam int MIN_CODE = 11;

  typedef enum logic [1:0] {
    XF_OK   = 2'd0,
    XF_MISS = 2'd1,
    XF_PERM = 2'd2
  } xfault_e;

  typedef enum logic [1:0] {
    AK_READ  = 2'd0,
    AK_WRITE = 2'd1,
    AK_EXEC  = 2'd2,
    AK_RSVD  = 2'd3
  } akind_e;

  typedef struct packed {
    logic [19:0] base;
    logic [4:0]  code;
  } seg_hi_t;

  typedef struct packed {
    logic [23:0] repl;
    logic [5:0]  perm;
  } seg_lo_t;

  // Power-up contents: identity map of the two halves of the logical space.
  function automatic seg_hi_t rst_hi(input int idx);
    seg_hi_t v;
    v = '0;
    if (idx == 0) begin
      v.base = 20'h00000; v.code = 5'h1E;
    end else if (idx == 1) begin
      v.base = 20'h80000; v.code = 5'h1E;
    end
    return v;
  endfunction

  function automatic seg_lo_t rst_lo(input int idx);
    seg_lo_t v;
    v = '0;
    if (idx == 0) begin
      v.repl = 24'h000000; v.perm = 6'h3F;
    end else if (idx == 1) begin
      v.repl = 24'h080000; v.perm = 6'h3F;
    end
    return v;
  endfunction

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 16,
  localparam int IDX_W  = $clog2(NUM_SEG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_wr,
  input  logic [IDX_W:0]           cfg_addr,
  input  logic [31:0]              cfg_wdata,
  output logic [31:0]              cfg_rdata,
  output seg_hi_t [NUM_SEG-1:0]    hi_q,
  output seg_lo_t [NUM_SEG-1:0]    lo_q
);

  logic [IDX_W-1:0] sel_idx;
  logic             sel_high;
  logic             unused_wbits;

  assign sel_idx      = cfg_addr[IDX_W:1];
  assign sel_high     = cfg_addr[0];
  assign unused_wbits = ^{cfg_wdata[11:5], cfg_wdata[7:6]};

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q[g] <= rst_hi(g);
        lo_q[g] <= rst_lo(g);
      end else if (cfg_wr && (sel_idx == IDX_W'(g))) begin
        if (sel_high) begin
          hi_q[g].base <= cfg_wdata[31:12];
          hi_q[g].code <= cfg_wdata[4:0];
        end else begin
          lo_q[g].repl <= cfg_wdata[31:8];
          lo_q[g].perm <= cfg_wdata[5:0];
        end
      end
    end
  end

  always_comb begin
    if (sel_high)
      cfg_rdata = {hi_q[sel_idx].base, 7'b0, hi_q[sel_idx].code};
    else
      cfg_rdata = {lo_q[sel_idx].repl, 2'b0, lo_q[sel_idx].perm};
  end

endmodule

// File: rtl/seg_match.sv
module seg_match
  import seg_xlate_pkg::*;
(
  input  seg_hi_t          hi,
  input  seg_lo_t          lo,
  input  logic [LA_W-1:0]  laddr,
  output logic             hit,
  output logic [PA_W-1:0]  paddr
);

  logic [5:0]      nbits;
  logic [LA_W-1:0] off_mask;
  logic            enabled;

  assign nbits    = {1'b0, hi.code} + 6'd1;
  assign off_mask = ~({LA_W{1'b1}} << nbits);
  assign enabled  = (hi.code >= 5'(MIN_CODE));
  assign hit      = enabled && (((laddr ^ {hi.base, 12'b0}) & ~off_mask) == '0);
  assign paddr    = ({lo.repl, 12'b0} & ~{4'b0, off_mask}) | {4'b0, laddr & off_mask};

endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 16,
  localparam int IDX_W  = $clog2(NUM_SEG)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_SEG-1:0]                hit,
  input  logic [NUM_SEG-1:0][PA_W-1:0]      paddr_in,
  input  seg_lo_t [NUM_SEG-1:0]             lo,
  input  logic [1:0]                        kind,
  input  logic                              priv,
  output xfault_e                           fault,
  output logic [PA_W-1:0]                   paddr,
  output logic [IDX_W-1:0]                  seg
);

  logic             any_hit;
  logic [5:0]       perm;
  logic [2:0]       pbit;
  logic             allowed;

  // Later (higher-numbered) hits override earlier ones.
  always_comb begin
    any_hit = 1'b0;
    seg     = '0;
    for (int i = 0; i < NUM_SEG; i++) begin
      if (hit[i]) begin
        any_hit = 1'b1;
        seg     = IDX_W'(i);
      end
    end
  end

  assign perm    = lo[seg].perm;
  assign pbit    = priv ? (3'd3 + {1'b0, kind}) : {1'b0, kind};
  assign allowed = (kind != AK_RSVD) && perm[pbit];

  always_comb begin
    if (!any_hit) begin
      fault = XF_MISS;
      paddr = '0;
    end else if (!allowed) begin
      fault = XF_PERM;
      paddr = '0;
    end else begin
      fault = XF_OK;
      paddr = paddr_in[seg];
    end
  end

  // R5
  ok_from_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault == XF_OK) |-> hit[seg]);

  // R7
  miss_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault == XF_MISS) |-> (hit == '0));

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 16,
  localparam int IDX_W  = $clog2(NUM_SEG),
  localparam int CFG_AW = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_addr,
  input  logic [1:0]        req_kind,
  input  logic              req_priv,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [35:0]       rsp_paddr,
  output logic [1:0]        rsp_fault,
  output logic [IDX_W-1:0]  rsp_seg
);

  seg_hi_t [NUM_SEG-1:0]           hi_q;
  seg_lo_t [NUM_SEG-1:0]           lo_q;
  logic [NUM_SEG-1:0]              hit;
  logic [NUM_SEG-1:0][PA_W-1:0]    seg_pa;
  xfault_e                         x_fault;
  logic [PA_W-1:0]                 x_paddr;
  logic [IDX_W-1:0]                x_seg;
  logic                            accept;

  seg_regfile #(.NUM_SEG(NUM_SEG)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .hi_q      (hi_q),
    .lo_q      (lo_q)
  );

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_match
    seg_match u_match (
      .hi    (hi_q[g]),
      .lo    (lo_q[g]),
      .laddr (req_addr),
      .hit   (hit[g]),
      .paddr (seg_pa[g])
    );
  end

  seg_select #(.NUM_SEG(NUM_SEG)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (hit),
    .paddr_in (seg_pa),
    .lo       (lo_q),
    .kind     (req_kind),
    .priv     (req_priv),
    .fault    (x_fault),
    .paddr    (x_paddr),
    .seg      (x_seg)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= XF_OK;
      rsp_seg   <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_paddr <= x_paddr;
      rsp_fault <= x_fault;
      rsp_seg   <= x_seg;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault) && $stable(rsp_seg)));

  // R9
  rsp_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid));

  // R4
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_fault != XF_OK || rsp_paddr[11:0] == $past(req_addr[11:0])));

  // R7
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == XF_MISS) |-> (rsp_paddr == '0 && rsp_seg == '0));

  // R6
  fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault != 2'd3));

endmodule

// File: tb/seg_xlate_unit_test.sv
`timescale 1ns/1ps
module seg_xlate_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_kind = '0;
  logic        req_priv = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [35:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic [3:0]  rsp_seg;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  seg_xlate_unit uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_kind(req_kind),
    .req_priv(req_priv), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_seg(rsp_seg)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input int seg, input bit high, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = {4'(seg), high}; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_check(input int seg, input bit high, input logic [31:0] exp, input string req);
    cfg_addr = {4'(seg), high};
    #1;
    check(cfg_rdata == exp, req, $sformatf("read seg%0d hi=%0d", seg, high), 64'(cfg_rdata), 64'(exp));
  endtask

  task automatic xlate(input logic [31:0] a, input logic [1:0] k, input bit p,
                       input logic [35:0] ep, input logic [1:0] ef, input logic [3:0] es,
                       input string req);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_kind = k; req_priv = p;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid && rsp_paddr == ep && rsp_fault == ef && rsp_seg == es, req,
          $sformatf("xlate 0x%08h {valid,fault,seg,paddr}", a),
          {rsp_valid, 13'b0, rsp_fault, 8'(rsp_seg), 4'b0, rsp_paddr},
          {1'b1, 13'b0, ef, 8'(es), 4'b0, ep});
  endtask

  task automatic t_reset;
    check(rsp_valid == 1'b0 && req_ready == 1'b1, "R1", "idle after reset",
          64'({rsp_valid, req_ready}), 64'b01);
    rd_check(0, 1, 32'h0000001E, "R1");
    rd_check(0, 0, 32'h0000003F, "R1");
    rd_check(1, 1, 32'h8000001E, "R1");
    rd_check(1, 0, 32'h0800003F, "R1");
    rd_check(7, 1, 32'h0, "R1");
    rd_check(15, 0, 32'h0, "R1");
  endtask

  task automatic t_default_map;
    xlate(32'h12345678, 2'd0, 1'b1, 36'h012345678, 2'd0, 4'd0, "R1");
    xlate(32'h9ABCDEF0, 2'd2, 1'b0, 36'h09ABCDEF0, 2'd0, 4'd1, "R1");
  endtask

  task automatic t_program_readback;
    wr_reg(2, 1, 32'h81000FF3 & 32'hFFFFF01F | 32'h00000013);
    wr_reg(2, 0, 32'h00C000FF);
    rd_check(2, 0, 32'h00C0003F, "R2");
    wr_reg(5, 1, 32'h12345FFF);
    rd_check(5, 1, 32'h1234501F, "R2");
    wr_reg(5, 1, 32'h0);
  endtask

  task automatic t_overlap;
    // seg2 (1 MB at 0x81000000) overrides seg1: R5
    xlate(32'h81012344, 2'd0, 1'b0, 36'h00C012344, 2'd0, 4'd2, "R5");
    xlate(32'h810FFFFC, 2'd1, 1'b1, 36'h00C0FFFFC, 2'd0, 4'd2, "R5");
    xlate(32'h82000000, 2'd0, 1'b1, 36'h082000000, 2'd0, 4'd1, "R5");
  endtask

  task automatic t_align_and_disable;
    wr_reg(2, 1, 32'h81080013);
    xlate(32'h81000010, 2'd0, 1'b1, 36'h00C000010, 2'd0, 4'd2, "R3");
    wr_reg(2, 1, 32'h8100000A);
    xlate(32'h81000010, 2'd0, 1'b1, 36'h081000010, 2'd0, 4'd1, "R3");
  endtask

  task automatic t_small_wide;
    wr_reg(3, 1, 32'h4000500B);
    wr_reg(3, 0, 32'hF123453F);
    xlate(32'h40005ABC, 2'd0, 1'b1, 36'hF12345ABC, 2'd0, 4'd3, "R4");
    xlate(32'h40005FFF, 2'd2, 1'b0, 36'hF12345FFF, 2'd0, 4'd3, "R3");
    xlate(32'h40006000, 2'd0, 1'b1, 36'h040006000, 2'd0, 4'd0, "R3");
    xlate(32'h40004FFF, 2'd0, 1'b1, 36'h040004FFF, 2'd0, 4'd0, "R3");
  endtask

  task automatic t_perm;
    wr_reg(4, 1, 32'h20000013);
    wr_reg(4, 0, 32'h0200000A);  // user write + supervisor read
    xlate(32'h20000004, 2'd1, 1'b0, 36'h020000004, 2'd0, 4'd4, "R6");
    xlate(32'h20000004, 2'd0, 1'b0, 36'h0,         2'd2, 4'd4, "R6");
    xlate(32'h20000004, 2'd2, 1'b0, 36'h0,         2'd2, 4'd4, "R6");
    xlate(32'h20000008, 2'd0, 1'b1, 36'h020000008, 2'd0, 4'd4, "R6");
    xlate(32'h20000008, 2'd1, 1'b1, 36'h0,         2'd2, 4'd4, "R6");
    xlate(32'h20000008, 2'd2, 1'b1, 36'h0,         2'd2, 4'd4, "R6");
    wr_reg(4, 0, 32'h02000024);  // user exec + supervisor exec
    xlate(32'h2000000C, 2'd2, 1'b0, 36'h02000000C, 2'd0, 4'd4, "R6");
    xlate(32'h2000000C, 2'd2, 1'b1, 36'h02000000C, 2'd0, 4'd4, "R6");
    // reserved kind on a fully permitted segment
    xlate(32'h00001000, 2'd3, 1'b1, 36'h0, 2'd2, 4'd0, "R8");
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_addr = 32'h00000100; req_kind = 2'd0; req_priv = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(rsp_valid && req_ready == 1'b0, "R9", "response pending, ready low",
          64'({rsp_valid, req_ready}), 64'b10);
    req_addr = 32'h90000000;
    repeat (3) @(negedge clk);
    check(rsp_valid && !req_ready && rsp_paddr == 36'h000000100 && rsp_seg == 4'd0, "R10",
          "held response", 64'(rsp_paddr), 64'h100);
    rsp_ready = 1'b1;
    #1;
    check(req_ready == 1'b1, "R10", "ready returns", 64'(req_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid && rsp_paddr == 36'h090000000 && rsp_seg == 4'd1, "R10",
          "waiting request taken", 64'(rsp_paddr), 64'h90000000);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R9", "response retired", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_miss;
    wr_reg(0, 1, 32'h0);
    wr_reg(1, 1, 32'h0);
    xlate(32'h50000000, 2'd0, 1'b1, 36'h0, 2'd1, 4'd0, "R7");
    xlate(32'hFFFFFFFF, 2'd0, 1'b1, 36'h0, 2'd1, 4'd0, "R7");
    xlate(32'h20000010, 2'd2, 1'b1, 36'h020000010, 2'd0, 4'd4, "R7");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_default_map;
    t_program_readback;
    t_overlap;
    t_align_and_disable;
    t_small_wide;
    t_perm;
    t_backpressure;
    t_miss;
    repeat (2) @(negedge clk);
    finish_run;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired before the run ended");
    finish_run;
  end

endmodule